// File: doc/BRIEF.md
# TDM Time Slot Router

This block connects one serial time-division multiplexed line to a small set of serial channel controllers, one bit at a time. It runs on the line's bit clock: each clock cycle is one bit period. A programmable schedule table splits each frame into slices. Each table word gives the slice length, the channel that owns the slice (or no channel), and whether the slice closes the frame. A frame sync pulse restarts the schedule at table word 0. The block then walks the words in order until a word marked final has run out, or until the table ends, or until the next frame sync.

While a slice is active, the owning channel gets a clock enable for every bit. It also sees the incoming line bit. The outgoing line is driven from that channel's transmit bit, and the output-enable is raised. During unowned slices, and between the end of the schedule and the next frame sync, nothing is enabled and the transmit line is released. A host port loads the table only while the block is disabled. After it is enabled, the block waits for a frame sync before it starts.

Schedule word layout (16 bits): bit 15 = final flag, bit 14 = byte-unit flag, bits 13:11 = length minus one, bits 10:4 = unused, bits 3:0 = channel code. Code 0 is null. Codes 1..NUM_CH select channel lane code-1. Any larger code is also treated as null.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset, no ch_rx_en bit is high and tx_en is low.
- R2: A host write (host_we high) takes effect only while enable is low. A write made while enable is high leaves the table unchanged.
- R3: While enable is high and no frame sync has yet been sampled, the block stays idle. When fsync is sampled high at a clock edge with enable high, the cycle after that edge carries bit 0 of word 0.
- R4: With the byte-unit flag at 0, a word's slice lasts (length field + 1) clock cycles.
- R5: With the byte-unit flag at 1, a word's slice lasts 8 × (length field + 1) clock cycles.
- R6: Words run strictly in address order with no gap. Consecutive words that name the same channel give one unbroken run of enables, so 8 + 7 bits give a 15-bit slot.
- R7: During a slice whose channel code is 0 or greater than NUM_CH, no ch_rx_en bit is high and tx_en is low.
- R8: After a word with the final flag (bit 15) completes, the block stays idle until the next frame sync.
- R9: A frame sync sampled at any point restarts at word 0 in the next cycle. This holds also when it coincides with the last bit of the final word.
- R10: During a slice owned by channel code c (1..NUM_CH), exactly ch_rx_en[c-1] is high, tx_en is high, tx_data equals ch_tx[c-1], and ch_rx_bit equals rx_bit.
- R11: If the table's last address completes without a final flag, the block goes idle until the next frame sync.
- R12: Dropping enable stops sequencing: the cycle after enable is sampled low is idle. A frame sync seen while enable is low does not start the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TDM bit clock, one bit period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global run enable; table writable only when low |
| fsync | input | 1 | Frame sync, sampled on the rising clock edge |
| rx_bit | input | 1 | Incoming line bit |
| ch_tx | input | NUM_CH | Transmit bit from each channel |
| host_we | input | 1 | Table write strobe |
| host_addr | input | $clog2(DEPTH) | Table write address |
| host_wdata | input | 16 | Table write word |
| ch_rx_en | output | NUM_CH | Per-channel bit clock enable |
| ch_rx_bit | output | 1 | Incoming bit presented to the channels |
| tx_data | output | 1 | Outgoing line bit |
| tx_en | output | 1 | Outgoing line drive enable (low = released) |

## Verification
The frame sync restart and the natural end of the final word can land on the same clock edge. In that case the restart must win, and word 0 must appear in the very next cycle rather than an idle gap. The bench provokes this by pulsing fsync exactly during the last bit of a final word. Each cycle it compares the observed owner against a schedule computed from the written table, shifted to the restart point. Frame syncs during a slice and a disable during a running frame are driven the same way, and the cycle after the edge is judged.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

   localparam int WORD_W = 16;
   localparam int CODE_W = 4;
   localparam int LEN_W  = 3;
   localparam int SPAN_W = 6;

   typedef struct packed {
      logic              final_w;
      logic              byte_unit;
      logic [LEN_W-1:0]  len_m1;
      logic [6:0]        spare;
      logic [CODE_W-1:0] code;
   } sched_word_t;

   // clocks in a slice minus one: bits -> n, bytes -> 8n+7
   function automatic logic [SPAN_W-1:0] span_m1(input logic byte_unit,
                                                 input logic [LEN_W-1:0] len_m1);
      if (byte_unit) span_m1 = {len_m1, 3'b111};
      else           span_m1 = {3'b000, len_m1};
   endfunction

endpackage

// File: rtl/tsa_sched_table.sv
module tsa_sched_table
   import tsa_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [AW-1:0]     rd_addr,
   output sched_word_t       rd_word
);

   sched_word_t store [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (wr_en && !locked && (int'(wr_addr) < DEPTH)) begin
         store[wr_addr] <= sched_word_t'(wr_word);
      end
   end

   assign rd_word = store[rd_addr];

   // R2
   write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_en && (int'(wr_addr) < DEPTH)) |=> (store[$past(wr_addr)] == $past(store[wr_addr])));

endmodule

// File: rtl/tsa_sequencer.sv
module tsa_sequencer
   import tsa_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             fsync,
   input  logic             w_final,
   input  logic             w_byte,
   input  logic [LEN_W-1:0] w_len_m1,
   output logic [AW-1:0]    ptr,
   output logic             running
);

   localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

   logic [SPAN_W-1:0] bit_cnt;
   logic [SPAN_W-1:0] span_end;
   logic              slice_done;
   logic              table_done;

   assign span_end   = span_m1(w_byte, w_len_m1);
   assign slice_done = (bit_cnt == span_end);
   assign table_done = w_final || (ptr == LAST_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         ptr     <= '0;
         bit_cnt <= '0;
      end else if (!enable) begin
         running <= 1'b0;
         ptr     <= '0;
         bit_cnt <= '0;
      end else if (fsync) begin
         running <= 1'b1;
         ptr     <= '0;
         bit_cnt <= '0;
      end else if (running) begin
         if (slice_done) begin
            bit_cnt <= '0;
            if (table_done) running <= 1'b0;
            else            ptr     <= ptr + 1'b1;
         end else begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   // R3
   no_start_without_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !(enable && fsync)) |=> !running);

   // R12
   halt_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !running);

   // R9
   sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && fsync) |=> (running && ptr == '0 && bit_cnt == '0));

   // R4 R5
   count_in_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (bit_cnt <= span_end));

endmodule

// File: rtl/tsa_lane_mux.sv
module tsa_lane_mux
   import tsa_pkg::*;
#(
   parameter int NUM_CH = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic [CODE_W-1:0] code,
   input  logic              rx_bit,
   input  logic [NUM_CH-1:0] ch_tx,
   output logic [NUM_CH-1:0] ch_rx_en,
   output logic              ch_rx_bit,
   output logic              tx_data,
   output logic              tx_en
);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(g + 1);
      assign ch_rx_en[g] = running && (code == MY_CODE);
   end

   assign tx_en     = |ch_rx_en;
   assign tx_data   = |(ch_rx_en & ch_tx);
   assign ch_rx_bit = rx_bit;

   // R10
   single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_rx_en));

endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
   import tsa_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              fsync,
   input  logic              rx_bit,
   input  logic [NUM_CH-1:0] ch_tx,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [NUM_CH-1:0] ch_rx_en,
   output logic              ch_rx_bit,
   output logic              tx_data,
   output logic              tx_en
);

   if (NUM_CH < 1 || NUM_CH > (2**CODE_W - 1)) begin : g_bad_ch
      $error("NUM_CH must lie in 1..15");
   end
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("DEPTH must lie in 2..256");
   end

   sched_word_t   cur_word;
   logic [AW-1:0] ptr;
   logic          running;
   logic          unused_spare;

   assign unused_spare = ^cur_word.spare;

   tsa_sched_table #(.DEPTH(DEPTH)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .locked  (enable),
      .wr_en   (host_we),
      .wr_addr (host_addr),
      .wr_word (host_wdata),
      .rd_addr (ptr),
      .rd_word (cur_word)
   );

   tsa_sequencer #(.DEPTH(DEPTH)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .fsync    (fsync),
      .w_final  (cur_word.final_w),
      .w_byte   (cur_word.byte_unit),
      .w_len_m1 (cur_word.len_m1),
      .ptr      (ptr),
      .running  (running)
   );

   tsa_lane_mux #(.NUM_CH(NUM_CH)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .running   (running),
      .code      (cur_word.code),
      .rx_bit    (rx_bit),
      .ch_tx     (ch_tx),
      .ch_rx_en  (ch_rx_en),
      .ch_rx_bit (ch_rx_bit),
      .tx_data   (tx_data),
      .tx_en     (tx_en)
   );

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (ch_rx_en == '0 && !tx_en));

endmodule

// File: tb/tdm_slot_router_test.sv
module tdm_slot_router_test;

   localparam int NCH  = 4;
   localparam int DEP  = 64;
   localparam int MAXC = 300;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           enable = 1'b0;
   logic           fsync = 1'b0;
   logic           rx_bit = 1'b0;
   logic [NCH-1:0] ch_tx = '0;
   logic           host_we = 1'b0;
   logic [5:0]     host_addr = '0;
   logic [15:0]    host_wdata = '0;
   logic [NCH-1:0] ch_rx_en;
   logic           ch_rx_bit;
   logic           tx_data;
   logic           tx_en;

   int checks = 0;
   int errors = 0;
   logic [15:0] shadow [DEP];
   int exp_seq [MAXC];

   tdm_slot_router #(.NUM_CH(NCH), .DEPTH(DEP)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fsync(fsync),
      .rx_bit(rx_bit), .ch_tx(ch_tx), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .ch_rx_en(ch_rx_en), .ch_rx_bit(ch_rx_bit),
      .tx_data(tx_data), .tx_en(tx_en)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic write_word(input int addr, input bit fin, input bit byt,
                             input int n_m1, input int code);
      logic [15:0] w;
      w = {fin, byt, 3'(n_m1), 7'd0, 4'(code)};
      @(negedge clk);
      host_we = 1'b1; host_addr = 6'(addr); host_wdata = w;
      if (!enable) shadow[addr] = w;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic set_enable(input bit v);
      @(negedge clk);
      enable = v;
   endtask

   // expected owner per cycle after a sync: 0 = nobody
   task automatic build_expected();
      int k;
      bit stop;
      k = 0; stop = 0;
      for (int i = 0; i < MAXC; i++) exp_seq[i] = 0;
      for (int e = 0; e < DEP && !stop; e++) begin
         int len;
         int c;
         len = shadow[e][14] ? (int'(shadow[e][13:11]) + 1) * 8 : int'(shadow[e][13:11]) + 1;
         c   = int'(shadow[e][3:0]);
         if (c > NCH) c = 0;
         for (int j = 0; j < len; j++) begin
            if (k < MAXC) exp_seq[k] = c;
            k++;
         end
         if (shadow[e][15]) stop = 1;
      end
   endtask

   // sync, then observe ncyc cycles; optional extra sync during cycle restart_at
   task automatic run_frame(input string req, input int ncyc, input int restart_at);
      int bad;
      int first_c, first_a, first_e;
      bad = 0; first_c = -1; first_a = 0; first_e = 0;
      build_expected();
      @(negedge clk);
      fsync = 1'b1;
      @(negedge clk);
      for (int c = 0; c < ncyc; c++) begin
         int e;
         logic [NCH-1:0] exp_en;
         logic exp_d;
         fsync  = (c == restart_at);
         rx_bit = c[0] ^ c[2];
         ch_tx  = NCH'(c * 5 + 3);
         #1;
         e = (restart_at >= 0 && c > restart_at) ? exp_seq[c - restart_at - 1] : exp_seq[c];
         exp_en = (e == 0) ? '0 : NCH'(1) << (e - 1);
         exp_d  = (e == 0) ? 1'b0 : ch_tx[e - 1];
         if (ch_rx_en !== exp_en || tx_en !== (e != 0) ||
             (e != 0 && tx_data !== exp_d) || ch_rx_bit !== rx_bit) begin
            bad++;
            if (first_c < 0) begin
               first_c = c; first_a = int'(ch_rx_en); first_e = int'(exp_en);
            end
         end
         @(negedge clk);
      end
      fsync = 1'b0;
      check(bad == 0, req, $sformatf("owner pattern (first bad cycle %0d, en)", first_c),
            first_a, first_e);
   endtask

   task automatic t_reset();
      #1;
      // R1
      check(ch_rx_en == '0, "R1", "ch_rx_en after reset", int'(ch_rx_en), 0);
      check(tx_en == 1'b0, "R1", "tx_en after reset", int'(tx_en), 0);
   endtask

   task automatic t_bit_slices();
      set_enable(0);
      write_word(0, 0, 0, 2, 1);
      write_word(1, 0, 0, 0, 2);
      write_word(2, 0, 0, 1, 0);
      write_word(3, 0, 0, 0, 9);
      write_word(4, 1, 0, 7, 3);
      set_enable(1);
      // R4 R7 R8 R10: bit-unit slices, null and out-of-range codes, final stop
      run_frame("R4/R7/R8/R10 bit slices", 22, -1);
   endtask

   task automatic t_byte_slices();
      set_enable(0);
      write_word(0, 0, 1, 0, 1);
      write_word(1, 0, 0, 6, 1);
      write_word(2, 1, 1, 1, 2);
      set_enable(1);
      // R5 R6: 8+7 bit run on lane 0, then 16 bits lane 1
      run_frame("R5/R6 byte slices", 36, -1);
      // R9: sync in the middle of a byte slice
      run_frame("R9 mid-slice sync", 40, 10);
   endtask

   task automatic t_sync_on_final_bit();
      set_enable(0);
      write_word(0, 0, 0, 1, 1);
      write_word(1, 1, 0, 2, 2);
      set_enable(1);
      // R9 R8: sync during the last bit of the final word
      run_frame("R9/R8 sync on final bit", 12, 4);
   endtask

   task automatic t_write_locked();
      // enable high: this write must be ignored
      write_word(0, 1, 0, 3, 4);
      // R2
      run_frame("R2 write while enabled", 8, -1);
   endtask

   task automatic t_disable_mid();
      @(negedge clk);
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      #1;
      check(ch_rx_en == 4'b0001, "R12", "running before disable", int'(ch_rx_en), 1);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      #1;
      // R12
      check(ch_rx_en == '0 && !tx_en, "R12", "idle after disable", int'(ch_rx_en), 0);
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      #1;
      check(ch_rx_en == '0 && !tx_en, "R12", "sync ignored while disabled", int'(ch_rx_en), 0);
   endtask

   task automatic t_table_end();
      set_enable(0);
      for (int i = 0; i < DEP; i++) write_word(i, 0, 0, 0, (i % NCH) + 1);
      set_enable(1);
      // R11: no final flag anywhere
      run_frame("R11 table end", 70, -1);
   endtask

   task automatic t_wait_for_sync();
      int busy;
      busy = 0;
      set_enable(0);
      set_enable(1);
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         #1;
         if (ch_rx_en != '0 || tx_en) busy++;
      end
      // R3
      check(busy == 0, "R3", "busy cycles before first sync", busy, 0);
      run_frame("R3 start on sync", 8, -1);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEP; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_bit_slices();
      t_byte_slices();
      t_sync_on_final_bit();
      t_write_locked();
      t_disable_mid();
      t_table_end();
      t_wait_for_sync();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule